// File: doc/BRIEF.md
# Single-Channel PWM Generator with Boundary-Aligned Updates

This block drives one pulse-width-modulated output from a prescaled counter. The counter advances once per prescaled tick and runs from 0 to `period - 1`. Every period opens at the inactive level. The output switches to the active level once the count reaches the duty threshold, so the active part of each period lasts `period - duty` ticks. A polarity input decides whether the active level is high or low.

While the channel is idle, its live settings follow the configuration inputs on every clock. Once it runs, those inputs are frozen out. The only way to change duty or period is an update write. That write waits in a buffer and is copied into the live value at the end of the running period, which is also the moment the period-start pulse marks. A stop request takes effect the same way: the running period finishes first, then the output parks at the inactive level and the counter is cleared.

Two buffer arrangements are available. The shared arrangement (`SHARED_BUF = 1`) has a single buffer, and each write's select bit chooses whether it targets duty or period. The split arrangement (`SHARED_BUF = 0`) has separate duty and period buffers.

Top module: `pwm_period_chan`

## Requirements
- R1: During and right after synchronous active-low reset, `pwm_out`, `chan_active` and `period_start` are 0.
- R2: While idle, the live period, duty, polarity and prescaler load from the configuration inputs on each clock. On the first clock edge where `en_req` is 1 in the idle state, `chan_active` rises, the count restarts at 0, and `period_start` is 1 for that cycle.
- R3: The count advances once every 2^p clocks, where p is `pre_sel`. A `pre_sel` value above 10 acts as 10.
- R4: Each period lasts `period` ticks. The output is inactive for counts below `duty` and active from `duty` onward, so it is active for `period - duty` ticks.
- R5: With `pol_inv` = 0 the active level is 1 and the inactive level is 0; with `pol_inv` = 1 both are inverted. Whenever the channel is idle, the output sits at the inactive level.
- R6: A duty of 0 gives a constant active output. A duty equal to the period gives a constant inactive output.
- R7: While the channel runs, changes on `cfg_period`, `cfg_duty`, `pol_inv` and `pre_sel` have no effect on the output.
- R8: An update write is applied only at the end of the running period. A write in the clock of the period's final tick is held and applied at the following period end.
- R9: Shared buffer: `upd_sel` = 0 targets duty and 1 targets period. A later write in the same period replaces both the value and the target of an earlier one.
- R10: Split buffers: a duty write and a period write in the same period are both applied at its end.
- R11: `period_start` is high for exactly the first cycle of each new period, and only while the channel runs.
- R12: After `en_req` drops, the current period completes with `chan_active` still 1. The channel then goes idle with no `period_start` pulse.
- R13: Update writes made while the channel is idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Run request (1 = run, 0 = stop at period end) |
| pre_sel | input | PRE_W | Prescaler exponent, clocks per tick = 2^pre_sel |
| pol_inv | input | 1 | Polarity: 0 active-high, 1 active-low |
| cfg_period | input | CNT_W | Period in ticks, taken while idle |
| cfg_duty | input | CNT_W | Inactive-part length in ticks, taken while idle |
| upd_wr | input | 1 | Update write strobe |
| upd_sel | input | 1 | Update target: 0 duty, 1 period |
| upd_data | input | CNT_W | Update value |
| pwm_out | output | 1 | Waveform |
| chan_active | output | 1 | Channel running |
| period_start | output | 1 | One-cycle pulse at each period start |

## Verification
Embedded properties are checked on every cycle. They cover the following: live settings never move inside a period, the run flag falls only at a period end, and start pulses occur only in a running channel at count zero. They also check that the first cycle of a period is inactive when duty is nonzero, that the idle output sits at the inactive level, that prescaler ticks are spaced apart, and that nothing stays pending while idle. Other behaviour needs the bench's scenarios against its reference model. Those scenarios cover exact period and duty lengths, the clamped prescaler, the hold of a write made in the final tick, the difference between shared and split buffers, and the idle-write and duty-extreme cases.

// File: rtl/pwm_chan_pkg.sv
// Shared constants and types for the PWM channel.
package pwm_chan_pkg;
    // Largest prescaler exponent honoured; larger requests are clamped.
    localparam int PRE_MAX = 10;

    // Target encoding of an update write.
    typedef enum logic {
        UPD_DUTY   = 1'b0,
        UPD_PERIOD = 1'b1
    } upd_tgt_e;
endpackage

// File: rtl/pwm_prescaler.sv
// Tick generator: emits one tick every 2^pre clocks while not held clear.
// Assumes pre is already clamped to PRE_MAX and constant while running.
module pwm_prescaler
    import pwm_chan_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int PCNT_W = PRE_MAX + 1;
    localparam logic [PCNT_W-1:0] ONE = PCNT_W'(1);

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] mask;

    // Low-bit mask for the selected exponent.
    always_comb mask = (ONE << pre) - ONE;

    // Free-running sub-tick counter, zeroed while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pcnt <= '0;
        else                 pcnt <= pcnt + ONE;
    end

    // Tick when all masked low bits are set.
    always_comb tick = ((pcnt & mask) == mask);

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && tick && pre != '0) |=> !tick);
endmodule

// File: rtl/pwm_upd_buf.sv
// Pending update storage. Holds duty/period writes made while running
// and offers the values to load at the period end. Writes while idle are
// dropped. SHARED selects one buffer with a target bit, or two buffers.
module pwm_upd_buf
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit SHARED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             end_evt,
    input  logic             wr,
    input  logic             sel,
    input  logic [CNT_W-1:0] data,
    input  logic [CNT_W-1:0] live_dty,
    input  logic [CNT_W-1:0] live_prd,
    output logic [CNT_W-1:0] nxt_dty,
    output logic [CNT_W-1:0] nxt_prd
);
    logic pend_any;

    generate
        if (SHARED) begin : g_shared
            logic             pend;
            upd_tgt_e         tgt;
            logic [CNT_W-1:0] buf_q;

            // One slot: a write overwrites value and target; end clears.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    pend  <= 1'b0;
                    tgt   <= UPD_DUTY;
                    buf_q <= '0;
                end else if (wr) begin
                    pend  <= 1'b1;
                    tgt   <= upd_tgt_e'(sel);
                    buf_q <= data;
                end else if (end_evt) begin
                    pend  <= 1'b0;
                end
            end

            // Route the slot to its target only.
            always_comb begin
                nxt_dty  = (pend && tgt == UPD_DUTY)   ? buf_q : live_dty;
                nxt_prd  = (pend && tgt == UPD_PERIOD) ? buf_q : live_prd;
                pend_any = pend;
            end
        end else begin : g_split
            logic             pd, pp;
            logic [CNT_W-1:0] bd, bp;

            // Independent duty and period slots.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    pd <= 1'b0; pp <= 1'b0; bd <= '0; bp <= '0;
                end else begin
                    if (end_evt) begin
                        pd <= 1'b0;
                        pp <= 1'b0;
                    end
                    if (wr && upd_tgt_e'(sel) == UPD_DUTY) begin
                        pd <= 1'b1;
                        bd <= data;
                    end
                    if (wr && upd_tgt_e'(sel) == UPD_PERIOD) begin
                        pp <= 1'b1;
                        bp <= data;
                    end
                end
            end

            // Offer each slot when pending.
            always_comb begin
                nxt_dty  = pd ? bd : live_dty;
                nxt_prd  = pp ? bp : live_prd;
                pend_any = pd | pp;
            end
        end
    endgenerate

    // R13
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pend_any);
endmodule

// File: rtl/pwm_wave.sv
// Output stage: inactive below the duty threshold, active from it on;
// parks at the inactive level when not running. Purely combinational.
module pwm_wave #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] dty,
    input  logic             pol,
    output logic             out
);
    // Level select with polarity applied.
    always_comb out = run ? ((cnt >= dty) ^ pol) : pol;
endmodule

// File: rtl/pwm_period_chan.sv
// One PWM channel. Loads settings from the configuration inputs while
// idle, runs a prescaled period counter, and applies buffered updates
// and stop requests only at period ends. Assumes a single clock domain.
module pwm_period_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 4,
    parameter bit SHARED_BUF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic             pol_inv,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_duty,
    input  logic             upd_wr,
    input  logic             upd_sel,
    input  logic [CNT_W-1:0] upd_data,
    output logic             pwm_out,
    output logic             chan_active,
    output logic             period_start
);
    localparam int               W1      = CNT_W + 1;
    localparam logic [W1-1:0]    ONE_W1  = W1'(1);
    localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRE_MAX);

    logic             active, start_q, tick, at_last, end_evt;
    logic             live_pol;
    logic [PRE_W-1:0] live_pre;
    logic [CNT_W-1:0] cnt, live_prd, live_dty, nxt_prd, nxt_dty;

    // Final tick of the period (a zero period behaves as one tick).
    always_comb begin
        at_last = ({1'b0, cnt} + ONE_W1) >= {1'b0, live_prd};
        end_evt = active && tick && at_last;
    end

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(!active), .pre(live_pre), .tick(tick)
    );

    pwm_upd_buf #(.CNT_W(CNT_W), .SHARED(SHARED_BUF)) u_buf (
        .clk(clk), .rst_n(rst_n), .run(active), .end_evt(end_evt),
        .wr(upd_wr), .sel(upd_sel), .data(upd_data),
        .live_dty(live_dty), .live_prd(live_prd),
        .nxt_dty(nxt_dty), .nxt_prd(nxt_prd)
    );

    pwm_wave #(.CNT_W(CNT_W)) u_wave (
        .run(active), .cnt(cnt), .dty(live_dty), .pol(live_pol), .out(pwm_out)
    );

    // Run state, start pulse and period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            start_q <= 1'b0;
            cnt     <= '0;
        end else if (!active) begin
            active  <= en_req;
            start_q <= en_req;
            cnt     <= '0;
        end else begin
            start_q <= 1'b0;
            if (end_evt) begin
                cnt     <= '0;
                active  <= en_req;
                start_q <= en_req;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Live settings: follow configuration when idle, buffer at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_prd <= '0;
            live_dty <= '0;
            live_pol <= 1'b0;
            live_pre <= '0;
        end else if (!active) begin
            live_prd <= cfg_period;
            live_dty <= cfg_duty;
            live_pol <= pol_inv;
            live_pre <= (pre_sel > PRE_LIM) ? PRE_LIM : pre_sel;
        end else if (end_evt) begin
            live_prd <= nxt_prd;
            live_dty <= nxt_dty;
        end
    end

    assign chan_active  = active;
    assign period_start = start_q;

    // R12
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && !end_evt) |=> chan_active);
    // R7
    live_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_active && !end_evt) |=> ($stable(live_prd) && $stable(live_dty)
                                       && $stable(live_pol) && $stable(live_pre)));
    // R11
    start_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (chan_active && cnt == '0));
    // R4
    start_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && live_dty != '0) |-> (pwm_out == live_pol));
    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_active |-> (pwm_out == live_pol));
endmodule

// File: tb/test_pwm_period_chan.sv
// Bench: drives both buffer variants with one stimulus and compares each
// against a behavioural reference model on every clock.
module test_pwm_period_chan;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0, rst_n = 1'b0, en = 1'b0, pol = 1'b0;
    logic          wr = 1'b0, sel = 1'b0;
    logic [3:0]    pre = 4'd0;
    logic [CW-1:0] prd = 16'd4, dty = 16'd1, wdat = '0;
    logic [1:0]    out_w, act_w, ps_w;

    int    n_chk = 0, n_fail = 0, cyc_cnt = 0;
    bit    cmp_on = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // Reference model state, index 0 shared buffer, 1 split buffers.
    int m_act[2], m_cnt[2], m_sub[2], m_ps[2], m_prd[2], m_dty[2];
    int m_pol[2], m_pre[2], m_pd[2], m_pp[2], m_bd[2], m_bp[2], m_tgt[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_period_chan #(.CNT_W(CW), .SHARED_BUF(1'b1)) i_pwm_period_chan (
        .clk(clk), .rst_n(rst_n), .en_req(en), .pre_sel(pre), .pol_inv(pol),
        .cfg_period(prd), .cfg_duty(dty), .upd_wr(wr), .upd_sel(sel),
        .upd_data(wdat), .pwm_out(out_w[0]), .chan_active(act_w[0]),
        .period_start(ps_w[0])
    );

    pwm_period_chan #(.CNT_W(CW), .SHARED_BUF(1'b0)) i_pwm_period_chan_sep (
        .clk(clk), .rst_n(rst_n), .en_req(en), .pre_sel(pre), .pol_inv(pol),
        .cfg_period(prd), .cfg_duty(dty), .upd_wr(wr), .upd_sel(sel),
        .upd_data(wdat), .pwm_out(out_w[1]), .chan_active(act_w[1]),
        .period_start(ps_w[1])
    );

    task automatic check(input string req, input string what, input int a, input int e);
        n_chk++;
        if (a != e) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, a, e, $time);
        end
    endtask

    function automatic int m_out(input int v);
        if (m_act[v] == 0) return m_pol[v];
        return ((m_cnt[v] >= m_dty[v]) ? 1 : 0) ^ m_pol[v];
    endfunction

    // One model clock for variant v, using the inputs seen at this edge.
    task automatic step(input int v);
        int tick_now;
        if (!rst_n) begin
            m_act[v] = 0; m_cnt[v] = 0; m_sub[v] = 0; m_ps[v] = 0;
            m_prd[v] = 0; m_dty[v] = 0; m_pol[v] = 0; m_pre[v] = 0;
            m_pd[v] = 0; m_pp[v] = 0; m_bd[v] = 0; m_bp[v] = 0; m_tgt[v] = 0;
        end else if (m_act[v] == 0) begin
            m_prd[v] = int'(prd); m_dty[v] = int'(dty); m_pol[v] = int'(pol);
            m_pre[v] = (int'(pre) > 10) ? 10 : int'(pre);
            m_pd[v] = 0; m_pp[v] = 0;
            m_act[v] = int'(en); m_ps[v] = int'(en); m_cnt[v] = 0; m_sub[v] = 0;
        end else begin
            m_ps[v] = 0;
            tick_now = (m_sub[v] == (1 << m_pre[v]) - 1) ? 1 : 0;
            m_sub[v] = tick_now ? 0 : m_sub[v] + 1;
            if (tick_now && m_cnt[v] + 1 >= m_prd[v]) begin
                if (v == 0) begin
                    if (m_pd[v] != 0 && m_tgt[v] == 0) m_dty[v] = m_bd[v];
                    if (m_pd[v] != 0 && m_tgt[v] == 1) m_prd[v] = m_bd[v];
                end else begin
                    if (m_pd[v] != 0) m_dty[v] = m_bd[v];
                    if (m_pp[v] != 0) m_prd[v] = m_bp[v];
                end
                m_pd[v] = 0; m_pp[v] = 0; m_cnt[v] = 0;
                if (en) m_ps[v] = 1;
                else begin m_act[v] = 0; m_sub[v] = 0; end
            end else if (tick_now) begin
                m_cnt[v] = m_cnt[v] + 1;
            end
            if (wr) begin
                if (v == 0) begin
                    m_pd[v] = 1; m_bd[v] = int'(wdat); m_tgt[v] = int'(sel);
                end else if (sel) begin
                    m_pp[v] = 1; m_bp[v] = int'(wdat);
                end else begin
                    m_pd[v] = 1; m_bd[v] = int'(wdat);
                end
            end
        end
    endtask

    always @(posedge clk) begin
        step(0);
        step(1);
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int v = 0; v < 2; v++) begin
                check(cur_req, $sformatf("v%0d pwm_out", v), int'(out_w[v]), m_out(v));
                check(cur_req, $sformatf("v%0d chan_active", v), int'(act_w[v]), m_act[v]);
                check(cur_req, $sformatf("v%0d period_start (R11)", v), int'(ps_w[v]), m_ps[v]);
            end
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > WATCHDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc_cnt, WATCHDOG);
            summary();
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stop at the negedge just before the period-final tick of variant 0.
    task automatic wait_end_next();
        do @(negedge clk);
        while (!(m_act[0] != 0 && m_sub[0] == (1 << m_pre[0]) - 1
                 && m_cnt[0] + 1 >= m_prd[0]));
    endtask

    task automatic wait_idle();
        do @(negedge clk);
        while (act_w != 2'b00);
    endtask

    initial begin
        cyc(3);
        // R1: outputs while reset is held
        for (int v = 0; v < 2; v++) begin
            check("R1", "pwm_out in reset", int'(out_w[v]), 0);
            check("R1", "chan_active in reset", int'(act_w[v]), 0);
            check("R1", "period_start in reset", int'(ps_w[v]), 0);
        end
        rst_n = 1'b1;
        cyc(1);
        cmp_on = 1'b1;

        // R2: start from idle
        cur_req = "R2";
        en = 1'b1;
        cyc(1);
        check("R2", "chan_active after enable", int'(act_w[0]), 1);
        check("R2", "period_start on first cycle", int'(ps_w[0]), 1);
        check("R2", "first cycle inactive", int'(out_w[0]), 0);
        cur_req = "R4,R11";
        cyc(12);

        // R8: mid-period duty write
        cur_req = "R8";
        wr = 1'b1; sel = 1'b0; wdat = 16'd3;
        cyc(1);
        wr = 1'b0;
        cyc(12);

        // R8: write in the final-tick clock is held one more period
        wait_end_next();
        wr = 1'b1; sel = 1'b0; wdat = 16'd2;
        cyc(1);
        wr = 1'b0;
        cyc(12);

        // R9 / R10: duty then period write in one period
        cur_req = "R9,R10";
        wait_end_next();
        cyc(1);
        wr = 1'b1; sel = 1'b0; wdat = 16'd1;
        cyc(1);
        sel = 1'b1; wdat = 16'd6;
        cyc(1);
        wr = 1'b0; sel = 1'b0;
        cyc(20);

        // R7: configuration changes while running
        cur_req = "R7";
        prd = 16'd9; dty = 16'd5; pol = 1'b1; pre = 4'd3;
        cyc(20);

        // R12: stop mid-period
        cur_req = "R12";
        en = 1'b0;
        cyc(1);
        check("R12", "active held after stop request", int'(act_w[0]), 1);
        cyc(20);
        check("R12", "idle after period end", int'(act_w[0]), 0);
        check("R12", "idle after period end split", int'(act_w[1]), 0);

        // R13 idle write ignored; R5 inverted polarity; R3 prescale 3
        cur_req = "R13,R5,R3";
        wr = 1'b1; sel = 1'b0; wdat = 16'd0;
        cyc(1);
        wr = 1'b0;
        check("R5", "idle level inverted", int'(out_w[0]), 1);
        en = 1'b1;
        cyc(9 * 8 * 2 + 5);
        en = 1'b0;
        wait_idle();

        // R3: exponent above the limit clamps to 10
        cur_req = "R3";
        pre = 4'd15; pol = 1'b0; prd = 16'd2; dty = 16'd1;
        cyc(1);
        en = 1'b1;
        cyc(2 * 1024 * 2 + 10);
        en = 1'b0;
        wait_idle();

        // R6: duty 0 then duty equal to period
        cur_req = "R6";
        pre = 4'd0; prd = 16'd3; dty = 16'd0;
        cyc(1);
        en = 1'b1;
        cyc(8);
        check("R6", "duty 0 constant active", int'(out_w[0]), 1);
        wr = 1'b1; sel = 1'b0; wdat = 16'd3;
        cyc(1);
        wr = 1'b0;
        cyc(10);
        check("R6", "duty=period constant inactive", int'(out_w[0]), 0);
        check("R6", "duty=period constant inactive split", int'(out_w[1]), 0);
        en = 1'b0;
        wait_idle();
        cyc(3);
        summary();
    end
endmodule